// File: doc/BRIEF.md
# Lockstep Multi-Thread Compute Core

This block is a compute core that runs a group of threads in lockstep. All threads share one program counter, one instruction fetcher and one decoder. Each thread has its own register file, arithmetic unit and memory port. The core walks every instruction through a fixed sequence of stages: FETCH, DECODE, REQUEST, WAIT, EXECUTE and UPDATE. In WAIT it holds until no thread still has a data-memory access outstanding. Both memories answer through a valid/acknowledge handshake with any latency, so a slow memory only lengthens the WAIT and FETCH stages.

A pulse on `start` latches the block index and runs the kernel from address 0. The core raises `done` when the kernel returns, and it stays quiet until the next `start`. Each thread sees three read-only registers: r13 holds the block index, r14 the number of threads and r15 its own thread number. One kernel can therefore compute a different data address in every thread.

Instructions are 16 bits wide. The opcode sits in bits [15:12]. Register fields sit in bits [11:8] (destination), [7:4] (first source) and [3:0] (second source). The field layout of each instruction is given in its requirement below. Data words are `DW` bits wide, and data addresses are one data word wide.

Top module: `simd_core`

## Requirements
- R1: While reset is held, and afterwards until `start` is seen, `done`, `prog_req_valid` and every `mem_req_valid` bit stay 0.
- R2: ADD (opcode 3), SUB (4) and MUL (5) write rs op rt into rd, taken modulo 2^DW, in every thread independently. The fields are rd=[11:8], rs=[7:4] and rt=[3:0].
- R3: DIV (opcode 6, same fields as R2) writes the unsigned integer quotient rs/rt into rd. When rt is zero, rd receives 0.
- R4: CONST (opcode 9) writes the zero-extended 8-bit immediate in [7:0] into rd=[11:8]. Registers r13, r14 and r15 always read as the block index, the thread count and the thread number. Writes to these three registers are ignored.
- R5: CMP (opcode 2, rs=[7:4], rt=[3:0]) stores the 3-bit flag set {rs<rt, rs==rt, rs>rt} (unsigned), with N in bit 2 and P in bit 0. BR (opcode 1) holds a mask in [11:9] and a target in [7:0]. It jumps to the target when the mask ANDed with the flags of thread 0 is nonzero, and otherwise continues at pc+1.
- R6: NOP (opcode 0) changes no register and only advances the program counter.
- R7: LDR (opcode 7, rd=[11:8], address register rs=[7:4]) and STR (opcode 8, address register [7:4], data register [3:0]) each raise one request per thread. The request, its write flag, address and data stay steady until that thread's `mem_rsp_valid`. No instruction fetch starts while any request is outstanding.
- R8: RET (opcode 15) ends the kernel. `done` then stays high with no fetch and no data request until `start`, which restarts the kernel at address 0.
- R9: `prog_req_valid` stays high with `prog_req_addr` unchanged until `prog_rsp_valid`, and the instruction word is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch kernel from address 0 (sampled while idle or done) |
| block_idx | input | DW | Block index, latched at launch, read through r13 |
| done | output | 1 | Kernel has returned |
| prog_req_valid | output | 1 | Instruction fetch request |
| prog_req_addr | output | 8 | Fetch address (program counter) |
| prog_rsp_valid | input | 1 | Fetch acknowledge, instruction valid |
| prog_rsp_data | input | 16 | Instruction word |
| mem_req_valid | output | THREADS | Per-thread data request |
| mem_req_we | output | THREADS | Per-thread write flag (1 = store) |
| mem_req_addr | output | THREADS*DW | Per-thread address, thread t in slice t |
| mem_req_wdata | output | THREADS*DW | Per-thread store data |
| mem_rsp_valid | input | THREADS | Per-thread acknowledge |
| mem_rsp_rdata | input | THREADS*DW | Per-thread load data, valid with acknowledge |

## Verification
Two events can fall in the same clock cycle. One is the acknowledge of the last outstanding thread request. The other is the core's decision in WAIT to move on. Several threads can also be acknowledged together, or apart in any order. The bench gives each thread its own memory latency, drawn from a rotating set, so across the sweep some threads complete together and others finish one by one after the rest. It varies the fetch latency as well. Each case is judged by the loaded and stored values in every thread's result slot. A port monitor also flags any cycle in which an instruction fetch overlaps a pending data request.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int INSTR_W  = 16;
  localparam int IMM_W    = 8;
  localparam int PC_W     = 8;
  localparam int RO_FIRST = 13;   // r13..r15 are read-only identity registers

  localparam logic [3:0] OP_NOP   = 4'h0;
  localparam logic [3:0] OP_BR    = 4'h1;
  localparam logic [3:0] OP_CMP   = 4'h2;
  localparam logic [3:0] OP_ADD   = 4'h3;
  localparam logic [3:0] OP_SUB   = 4'h4;
  localparam logic [3:0] OP_MUL   = 4'h5;
  localparam logic [3:0] OP_DIV   = 4'h6;
  localparam logic [3:0] OP_LDR   = 4'h7;
  localparam logic [3:0] OP_STR   = 4'h8;
  localparam logic [3:0] OP_CONST = 4'h9;
  localparam logic [3:0] OP_RET   = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_REQUEST,
    ST_WAIT, ST_EXECUTE, ST_UPDATE, ST_DONE
  } stage_e;

  typedef struct packed {
    logic [3:0]       op;
    logic [3:0]       rd;
    logic [3:0]       rs;
    logic [3:0]       rt;
    logic [IMM_W-1:0] imm;
    logic [2:0]       mask;
    logic             wr_en;
    logic             is_ld;
    logic             is_st;
    logic             is_cmp;
    logic             is_br;
    logic             is_ret;
  } dec_t;
endpackage

// File: rtl/simd_frontend.sv
module simd_frontend
  import simd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_en,
  input  logic               decode_en,
  input  logic [PC_W-1:0]    pc,
  output logic               prog_req_valid,
  output logic [PC_W-1:0]    prog_req_addr,
  input  logic               prog_rsp_valid,
  input  logic [INSTR_W-1:0] prog_rsp_data,
  output dec_t               dec
);
  logic [INSTR_W-1:0] instr_q, instr_d;
  dec_t               dec_q, dec_d, dec_c;

  assign prog_req_valid = fetch_en;
  assign prog_req_addr  = pc;

  // instruction capture
  always_comb begin
    instr_d = instr_q;
    if (fetch_en && prog_rsp_valid) instr_d = prog_rsp_data;
  end

  // field split and class decode
  always_comb begin
    dec_c      = '0;
    dec_c.op   = instr_q[15:12];
    dec_c.rd   = instr_q[11:8];
    dec_c.rs   = instr_q[7:4];
    dec_c.rt   = instr_q[3:0];
    dec_c.imm  = instr_q[7:0];
    dec_c.mask = instr_q[11:9];
    case (instr_q[15:12])
      OP_ADD, OP_SUB, OP_MUL, OP_DIV: dec_c.wr_en = 1'b1;
      OP_LDR: begin
        dec_c.wr_en = 1'b1;
        dec_c.is_ld = 1'b1;
      end
      OP_STR:   dec_c.is_st  = 1'b1;
      OP_CONST: dec_c.wr_en  = 1'b1;
      OP_CMP:   dec_c.is_cmp = 1'b1;
      OP_BR:    dec_c.is_br  = 1'b1;
      OP_RET:   dec_c.is_ret = 1'b1;
      default:  dec_c.wr_en  = 1'b0;
    endcase
  end

  always_comb begin
    dec_d = dec_q;
    if (decode_en) dec_d = dec_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0;
      dec_q   <= '0;
    end else begin
      instr_q <= instr_d;
      dec_q   <= dec_d;
    end
  end

  assign dec = dec_q;
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic [2:0]    nzp
);
  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = a * b;
      OP_DIV:  res = (b == '0) ? '0 : a / b;
      default: res = '0;
    endcase
  end

  assign nzp = {a < b, a == b, a > b};
endmodule

// File: rtl/simd_regfile.sv
module simd_regfile
  import simd_pkg::*;
#(
  parameter int DW      = 8,
  parameter int THREADS = 4,
  parameter int TID     = 0
) (
  input  logic          clk,
  input  logic          we,
  input  logic [3:0]    wa,
  input  logic [DW-1:0] wd,
  input  logic [3:0]    ra_a,
  input  logic [3:0]    ra_b,
  input  logic [DW-1:0] blk,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);
  logic [DW-1:0] regs [RO_FIRST];

  // datapath storage, no reset
  always_ff @(posedge clk) begin
    if (we && (wa < 4'(RO_FIRST))) regs[wa] <= wd;
  end

  always_comb begin
    case (ra_a)
      4'd13:   rd_a = blk;
      4'd14:   rd_a = DW'(THREADS);
      4'd15:   rd_a = DW'(TID);
      default: rd_a = regs[ra_a];
    endcase
    case (ra_b)
      4'd13:   rd_b = blk;
      4'd14:   rd_b = DW'(THREADS);
      4'd15:   rd_b = DW'(TID);
      default: rd_b = regs[ra_b];
    endcase
  end
endmodule

// File: rtl/simd_lsu.sv
module simd_lsu #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          is_ld,
  input  logic          is_st,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  output logic          req_valid,
  output logic          req_we,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic [DW-1:0] ld_data
);
  logic          pend_q, pend_d, we_q, we_d;
  logic [DW-1:0] addr_q, addr_d, wdata_q, wdata_d, ld_q, ld_d;

  always_comb begin
    pend_d  = pend_q;
    we_d    = we_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    ld_d    = ld_q;
    if (issue && (is_ld || is_st)) begin
      pend_d  = 1'b1;
      we_d    = is_st;
      addr_d  = addr;
      wdata_d = wdata;
    end else if (pend_q && rsp_valid) begin
      pend_d = 1'b0;
      if (!we_q) ld_d = rsp_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ld_q    <= '0;
    end else begin
      pend_q  <= pend_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      ld_q    <= ld_d;
    end
  end

  assign req_valid = pend_q;
  assign req_we    = we_q;
  assign req_addr  = addr_q;
  assign req_wdata = wdata_q;
  assign ld_data   = ld_q;
endmodule

// File: rtl/simd_core.sv
module simd_core
  import simd_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int DW      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [DW-1:0]         block_idx,
  output logic                  done,
  output logic                  prog_req_valid,
  output logic [PC_W-1:0]       prog_req_addr,
  input  logic                  prog_rsp_valid,
  input  logic [INSTR_W-1:0]    prog_rsp_data,
  output logic [THREADS-1:0]    mem_req_valid,
  output logic [THREADS-1:0]    mem_req_we,
  output logic [THREADS*DW-1:0] mem_req_addr,
  output logic [THREADS*DW-1:0] mem_req_wdata,
  input  logic [THREADS-1:0]    mem_rsp_valid,
  input  logic [THREADS*DW-1:0] mem_rsp_rdata
);
  stage_e             stage_q, stage_d;
  logic [PC_W-1:0]    pc_q, pc_d;
  logic [DW-1:0]      blk_q, blk_d;
  dec_t               dec;
  logic [THREADS-1:0] busy;
  logic [2:0]         nzp_lead;
  logic               taken;

  simd_frontend u_fe (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_en       (stage_q == ST_FETCH),
    .decode_en      (stage_q == ST_DECODE),
    .pc             (pc_q),
    .prog_req_valid (prog_req_valid),
    .prog_req_addr  (prog_req_addr),
    .prog_rsp_valid (prog_rsp_valid),
    .prog_rsp_data  (prog_rsp_data),
    .dec            (dec)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [DW-1:0] op_a, op_b, alu_res, alu_q, alu_d, ld_val, wb_val;
    logic [2:0]    cmp_res, nzp_q, nzp_d;

    simd_regfile #(.DW(DW), .THREADS(THREADS), .TID(t)) u_rf (
      .clk  (clk),
      .we   ((stage_q == ST_UPDATE) && dec.wr_en),
      .wa   (dec.rd),
      .wd   (wb_val),
      .ra_a (dec.rs),
      .ra_b (dec.rt),
      .blk  (blk_q),
      .rd_a (op_a),
      .rd_b (op_b)
    );

    simd_alu #(.DW(DW)) u_alu (
      .op  (dec.op),
      .a   (op_a),
      .b   (op_b),
      .res (alu_res),
      .nzp (cmp_res)
    );

    simd_lsu #(.DW(DW)) u_lsu (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (stage_q == ST_REQUEST),
      .is_ld     (dec.is_ld),
      .is_st     (dec.is_st),
      .addr      (op_a),
      .wdata     (op_b),
      .rsp_valid (mem_rsp_valid[t]),
      .rsp_rdata (mem_rsp_rdata[t*DW +: DW]),
      .req_valid (busy[t]),
      .req_we    (mem_req_we[t]),
      .req_addr  (mem_req_addr[t*DW +: DW]),
      .req_wdata (mem_req_wdata[t*DW +: DW]),
      .ld_data   (ld_val)
    );

    always_comb begin
      alu_d = alu_q;
      nzp_d = nzp_q;
      if (stage_q == ST_EXECUTE) begin
        alu_d = alu_res;
        if (dec.is_cmp) nzp_d = cmp_res;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alu_q <= '0;
        nzp_q <= '0;
      end else begin
        alu_q <= alu_d;
        nzp_q <= nzp_d;
      end
    end

    always_comb begin
      if (dec.is_ld)               wb_val = ld_val;
      else if (dec.op == OP_CONST) wb_val = DW'(dec.imm);
      else                         wb_val = alu_q;
    end

    if (t == 0) begin : g_lead
      assign nzp_lead = nzp_q;
    end
  end

  assign mem_req_valid = busy;
  assign taken         = dec.is_br && (|(dec.mask & nzp_lead));

  always_comb begin
    stage_d = stage_q;
    pc_d    = pc_q;
    blk_d   = blk_q;
    case (stage_q)
      ST_IDLE, ST_DONE: if (start) begin
        stage_d = ST_FETCH;
        pc_d    = '0;
        blk_d   = block_idx;
      end
      ST_FETCH:   if (prog_rsp_valid) stage_d = ST_DECODE;
      ST_DECODE:  stage_d = ST_REQUEST;
      ST_REQUEST: stage_d = ST_WAIT;
      ST_WAIT:    if (busy == '0) stage_d = ST_EXECUTE;
      ST_EXECUTE: stage_d = ST_UPDATE;
      ST_UPDATE: begin
        if (dec.is_ret) begin
          stage_d = ST_DONE;
        end else begin
          stage_d = ST_FETCH;
          pc_d    = taken ? dec.imm : pc_q + PC_W'(1);
        end
      end
      default: stage_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      pc_q    <= '0;
      blk_q   <= '0;
    end else begin
      stage_q <= stage_d;
      pc_q    <= pc_d;
      blk_q   <= blk_d;
    end
  end

  assign done = (stage_q == ST_DONE);
endmodule

// File: rtl/simd_core_chk.sv
module simd_core_chk
  import simd_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int DW      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  done,
  input logic                  prog_req_valid,
  input logic [PC_W-1:0]       prog_req_addr,
  input logic                  prog_rsp_valid,
  input logic [THREADS-1:0]    mem_req_valid,
  input logic [THREADS*DW-1:0] mem_req_addr,
  input logic [THREADS-1:0]    mem_rsp_valid
);
  p_fetch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req_valid && !prog_rsp_valid) |=> (prog_req_valid && $stable(prog_req_addr)));

  p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_req_valid & ~mem_rsp_valid) != '0) |=>
      (((mem_req_valid & $past(mem_req_valid & ~mem_rsp_valid))
        == $past(mem_req_valid & ~mem_rsp_valid)) && $stable(mem_req_addr)));

  p_no_fetch_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid != '0) |-> !prog_req_valid);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!prog_req_valid && (mem_req_valid == '0)));

  p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_restart_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (prog_req_valid && (prog_req_addr == '0)));
endmodule

bind simd_core simd_core_chk #(.THREADS(THREADS), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .done           (done),
  .prog_req_valid (prog_req_valid),
  .prog_req_addr  (prog_req_addr),
  .prog_rsp_valid (prog_rsp_valid),
  .mem_req_valid  (mem_req_valid),
  .mem_req_addr   (mem_req_addr),
  .mem_rsp_valid  (mem_rsp_valid)
);

// File: tb/sim_simd_core.sv
`timescale 1ns/1ps
module sim_simd_core;
  localparam int T  = 4;
  localparam int DW = 8;

  logic          clk, rst_n, start, done;
  logic [DW-1:0] block_idx;
  logic          prog_req_valid, prog_rsp_valid;
  logic [7:0]    prog_req_addr;
  logic [15:0]   prog_rsp_data;
  logic [T-1:0]  mem_req_valid, mem_req_we, mem_rsp_valid;
  logic [T*DW-1:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;

  simd_core #(.THREADS(T), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .block_idx(block_idx), .done(done),
    .prog_req_valid(prog_req_valid), .prog_req_addr(prog_req_addr),
    .prog_rsp_valid(prog_rsp_valid), .prog_rsp_data(prog_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] pmem [256];
  logic [7:0]  dmem [256];
  int plat, lat_base, pwait;
  int twait [T];
  int n_chk, n_fail;
  int overlap_cnt, addr_jump_cnt, quiet_fetch_cnt;
  logic prev_pvalid, prev_prsp, quiet;
  logic [7:0] prev_paddr;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // instruction encoders
  function automatic logic [15:0] e_alu(input logic [3:0] op, rd, rs, rt);
    return {op, rd, rs, rt};
  endfunction
  function automatic logic [15:0] e_const(input logic [3:0] rd, input logic [7:0] imm);
    return {4'h9, rd, imm};
  endfunction
  function automatic logic [15:0] e_br(input logic [2:0] mask, input logic [7:0] tgt);
    return {4'h1, mask, 1'b0, tgt};
  endfunction
  function automatic logic [15:0] e_ldr(input logic [3:0] rd, rs);
    return {4'h7, rd, rs, 4'h0};
  endfunction
  function automatic logic [15:0] e_str(input logic [3:0] ra, rv);
    return {4'h8, 4'h0, ra, rv};
  endfunction
  function automatic logic [15:0] e_cmp(input logic [3:0] ra, rb);
    return {4'h2, 4'h0, ra, rb};
  endfunction

  function automatic int val_a(input int p, input int g);
    return (g * 37 + p * 11 + 5) & 255;
  endfunction
  function automatic int val_b(input int p, input int g);
    if (p == 1) return 0;
    if (p == 2) return g % 3;
    return (g * 13 + 7) & 255;
  endfunction

  // memory models and port monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if (prog_req_valid && (mem_req_valid != '0)) overlap_cnt++;
      if (prev_pvalid && prog_req_valid && !prev_prsp && (prog_req_addr != prev_paddr))
        addr_jump_cnt++;
      if (quiet && (prog_req_valid || (mem_req_valid != '0))) quiet_fetch_cnt++;
      prev_pvalid = prog_req_valid;
      prev_paddr  = prog_req_addr;
      prev_prsp   = prog_rsp_valid;

      if (prog_rsp_valid) prog_rsp_valid = 1'b0;
      else if (prog_req_valid) begin
        if (pwait >= plat) begin
          prog_rsp_valid = 1'b1;
          prog_rsp_data  = pmem[prog_req_addr];
          pwait = 0;
        end else pwait++;
      end

      for (int i = 0; i < T; i++) begin
        if (mem_rsp_valid[i]) mem_rsp_valid[i] = 1'b0;
        else if (mem_req_valid[i]) begin
          if (twait[i] >= (i + lat_base) % 4) begin
            mem_rsp_valid[i] = 1'b1;
            if (mem_req_we[i]) dmem[mem_req_addr[i*DW +: DW]] = mem_req_wdata[i*DW +: DW];
            else mem_rsp_rdata[i*DW +: DW] = dmem[mem_req_addr[i*DW +: DW]];
            twait[i] = 0;
          end else twait[i]++;
        end
      end
    end
  end

  task automatic load_kernel_a();
    for (int i = 0; i < 256; i++) pmem[i] = 16'hF000;
    pmem[0]  = e_alu(4'h5, 4'd2, 4'd13, 4'd14);
    pmem[1]  = e_alu(4'h3, 4'd2, 4'd2, 4'd15);
    pmem[2]  = e_ldr(4'd3, 4'd2);
    pmem[3]  = e_const(4'd4, 8'd64);
    pmem[4]  = e_alu(4'h3, 4'd4, 4'd4, 4'd2);
    pmem[5]  = e_ldr(4'd5, 4'd4);
    pmem[6]  = e_alu(4'h3, 4'd6, 4'd3, 4'd5);
    pmem[7]  = e_const(4'd7, 8'd128);
    pmem[8]  = e_alu(4'h3, 4'd7, 4'd7, 4'd2);
    pmem[9]  = e_str(4'd7, 4'd6);
    pmem[10] = e_alu(4'h4, 4'd6, 4'd3, 4'd5);
    pmem[11] = e_const(4'd7, 8'd144);
    pmem[12] = e_alu(4'h3, 4'd7, 4'd7, 4'd2);
    pmem[13] = e_str(4'd7, 4'd6);
    pmem[14] = e_alu(4'h5, 4'd6, 4'd3, 4'd5);
    pmem[15] = e_const(4'd7, 8'd160);
    pmem[16] = e_alu(4'h3, 4'd7, 4'd7, 4'd2);
    pmem[17] = e_str(4'd7, 4'd6);
    pmem[18] = e_alu(4'h6, 4'd6, 4'd3, 4'd5);
    pmem[19] = e_const(4'd7, 8'd176);
    pmem[20] = e_alu(4'h3, 4'd7, 4'd7, 4'd2);
    pmem[21] = e_str(4'd7, 4'd6);
    pmem[22] = 16'h0000;
    pmem[23] = e_const(4'd15, 8'd99);
    pmem[24] = e_const(4'd7, 8'd192);
    pmem[25] = e_alu(4'h3, 4'd7, 4'd7, 4'd2);
    pmem[26] = e_str(4'd7, 4'd15);
    pmem[27] = 16'hF000;
  endtask

  task automatic load_kernel_b();
    for (int i = 0; i < 256; i++) pmem[i] = 16'hF000;
    pmem[0]  = e_const(4'd11, 8'h5A);
    pmem[1]  = e_const(4'd10, 8'd0);
    pmem[2]  = e_const(4'd0, 8'd0);
    pmem[3]  = e_const(4'd1, 8'd0);
    pmem[4]  = e_const(4'd8, 8'd1);
    pmem[5]  = e_const(4'd9, 8'd5);
    pmem[6]  = e_alu(4'h3, 4'd0, 4'd0, 4'd15);
    pmem[7]  = e_alu(4'h3, 4'd1, 4'd1, 4'd8);
    pmem[8]  = e_cmp(4'd1, 4'd9);
    pmem[9]  = e_br(3'b100, 8'd6);
    pmem[10] = 16'h0000;
    pmem[11] = e_br(3'b001, 8'd13);
    pmem[12] = e_const(4'd10, 8'd7);
    pmem[13] = e_br(3'b010, 8'd15);
    pmem[14] = e_const(4'd10, 8'd9);
    pmem[15] = e_alu(4'h5, 4'd2, 4'd13, 4'd14);
    pmem[16] = e_alu(4'h3, 4'd2, 4'd2, 4'd15);
    pmem[17] = e_const(4'd7, 8'd208);
    pmem[18] = e_alu(4'h3, 4'd7, 4'd7, 4'd2);
    pmem[19] = e_str(4'd7, 4'd0);
    pmem[20] = e_const(4'd7, 8'd224);
    pmem[21] = e_alu(4'h3, 4'd7, 4'd7, 4'd2);
    pmem[22] = e_str(4'd7, 4'd10);
    pmem[23] = e_const(4'd7, 8'd240);
    pmem[24] = e_alu(4'h3, 4'd7, 4'd7, 4'd2);
    pmem[25] = e_str(4'd7, 4'd11);
    pmem[26] = e_br(3'b000, 8'd0);
    pmem[27] = 16'hF000;
  endtask

  task automatic run(input int blk);
    @(negedge clk);
    quiet     = 1'b0;
    block_idx = blk[DW-1:0];
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    quiet = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 done held after return", int'(done), 1);
    chk("R8 no activity while done", quiet_fetch_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog: done actual 0 expected 1");
    summary();
  end

  initial begin
    n_chk = 0; n_fail = 0; overlap_cnt = 0; addr_jump_cnt = 0; quiet_fetch_cnt = 0;
    prev_pvalid = 1'b0; prev_prsp = 1'b0; prev_paddr = '0; quiet = 1'b0;
    rst_n = 1'b0; start = 1'b0; block_idx = '0;
    prog_rsp_valid = 1'b0; prog_rsp_data = '0;
    mem_rsp_valid = '0; mem_rsp_rdata = '0;
    plat = 0; lat_base = 0; pwait = 0;
    for (int i = 0; i < T; i++) twait[i] = 0;

    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 fetch in reset", int'(prog_req_valid), 0);
    chk("R1 mem req in reset", int'(mem_req_valid), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 idle fetch before start", int'(prog_req_valid), 0);
    chk("R1 idle done before start", int'(done), 0);
    chk("R1 idle mem req before start", int'(mem_req_valid), 0);

    load_kernel_a();
    for (int p = 0; p < 3; p++) begin
      for (int blk = 0; blk < 4; blk++) begin
        plat = (p + blk) % 3;
        lat_base = blk + p;
        for (int i = 0; i < 256; i++) dmem[i] = 8'hEE;
        for (int g = 0; g < 16; g++) begin
          dmem[g]      = val_a(p, g)[7:0];
          dmem[64 + g] = val_b(p, g)[7:0];
        end
        run(blk);
        for (int t = 0; t < T; t++) begin
          int g, a, b;
          g = blk * T + t;
          a = val_a(p, g);
          b = val_b(p, g);
          chk("R2 add", int'(dmem[128 + g]), (a + b) & 255);
          chk("R2 sub", int'(dmem[144 + g]), (a - b) & 255);
          chk("R2 mul", int'(dmem[160 + g]), (a * b) & 255);
          chk("R3 div", int'(dmem[176 + g]), (b == 0) ? 0 : a / b);
          chk("R4 read-only thread index", int'(dmem[192 + g]), t);
        end
      end
    end

    load_kernel_b();
    for (int blk = 0; blk < 3; blk++) begin
      plat = blk;
      lat_base = 3 * blk + 1;
      for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
      run(blk);
      for (int t = 0; t < T; t++) begin
        int g;
        g = blk * T + t;
        chk("R5 loop via CMP/BR", int'(dmem[208 + g]), (5 * t) & 255);
        chk("R5 branch taken/not taken", int'(dmem[224 + g]), 7);
        chk("R6 NOP keeps registers", int'(dmem[240 + g]), 90);
      end
    end

    chk("R7 fetch overlapping data request", overlap_cnt, 0);
    chk("R9 fetch address changed before ack", addr_jump_cnt, 0);
    summary();
  end
endmodule